// File: doc/BRIEF.md
# Dual-Channel Host Bus Front End

This block sits between an 8-bit asynchronous host bus and two serial channels. The host picks a channel with one of two active-low selects and a register with a 3-bit address. It moves data with active-low read and write strobes that have no fixed timing relation to the system clock. The block brings all bus inputs into the clock domain through two-flop synchronizers. It finds strobe edges on the synchronized copies and turns them into single-cycle write enables for the chosen channel. On reads it holds the addressed register value on a modelled data bus for as long as the read strobe stays low.

Each channel's registers are modelled here as a plain file of eight bytes. The register at address 4 is the modem-control register, and its bit 3 gates that channel's interrupt pin. When the bit is set, the interrupt output is driven with the channel's internal request and an active-low auxiliary output goes low. When the bit is clear, the interrupt output is released to high impedance and the auxiliary output sits high. The data bus and the interrupt pins are modelled as separate value and output-enable signals.

Top module: `hbi_dual_front`

## Requirements
- R1: After an active-high synchronous reset, all sixteen registers read 0x00, data_oe is 0 and data_out is 0x00, both interrupt enables are 0, and both auxiliary outputs are 1.
- R2: A write with only cs_a_n low stores data_in in channel A's register at addr, and the byte stored is the one present when wr_n rises. Channel B is left unchanged.
- R3: A write with only cs_b_n low stores into channel B in the same way and leaves channel A unchanged.
- R4: While rd_n is low with exactly one select low, data_oe is 1 and data_out holds the addressed register of that channel. Both are valid no later than 4 clock cycles after rd_n falls.
- R5: Within 4 clock cycles after rd_n rises, data_oe returns to 0 and data_out to 0x00.
- R6: With both selects low at once, a write changes no register, and a read leaves data_oe at 0 and data_out at 0x00.
- R7: With neither select low, strobes change no register and do not drive the bus.
- R8: When bit 3 of a channel's register at address 4 is 1, that channel's interrupt output enable is 1, its interrupt output follows the channel's irq request input, and its auxiliary output is 0. When the bit is 0, the enable is 0, the interrupt output is 0 and the auxiliary output is 1.
- R9: The eight addresses of each channel are separate storage; writing one address changes no other.
- R10: If data_in changes while wr_n is low, the register gets the last value present before wr_n rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_a_n | input | 1 | Channel A select, active low |
| cs_b_n | input | 1 | Channel B select, active low |
| addr | input | 3 | Register address within the channel |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| data_in | input | 8 | Write data from the host |
| data_out | output | 8 | Read data toward the host |
| data_oe | output | 1 | Data bus drive enable |
| irq_a | input | 1 | Channel A internal interrupt request |
| irq_b | input | 1 | Channel B internal interrupt request |
| int_a | output | 1 | Channel A interrupt pin value |
| int_a_oe | output | 1 | Channel A interrupt pin drive enable |
| int_b | output | 1 | Channel B interrupt pin value |
| int_b_oe | output | 1 | Channel B interrupt pin drive enable |
| aux_a_n | output | 1 | Channel A auxiliary output, active low |
| aux_b_n | output | 1 | Channel B auxiliary output, active low |

## Verification
The assertions assume that address, select and write data are stable before a strobe edge and stay stable until the synchronized edge has been acted on. They also assume that read and write strobes are never low together. The stimulus meets this in every bus task. It sets selects, address and data one cycle before lowering a strobe, holds them for several cycles after releasing it, and never overlaps the two strobes. The only deliberate change is to data_in while the write strobe is low, and that change settles well before the rising edge.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
    parameter int DATA_W      = 8;
    parameter int ADDR_W      = 3;
    parameter int NUM_CH      = 2;
    parameter int NUM_REGS    = 1 << ADDR_W;
    parameter int CTRL_ADDR   = 4;
    parameter int IRQ_EN_BIT  = 3;
    localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] radr_t;
    typedef logic [CH_W-1:0]   ch_t;

    typedef struct packed {
        logic              rd_n;
        logic              wr_n;
        logic [NUM_CH-1:0] cs_n;
    } strobe_t;

    typedef struct packed {
        logic              rd_go;
        logic              rd_done;
        logic [NUM_CH-1:0] wr_go;
    } access_t;

    function automatic logic sel_ok(input logic [NUM_CH-1:0] cs_n);
        return $countones(~cs_n) == 1;
    endfunction

    function automatic ch_t sel_idx(input logic [NUM_CH-1:0] cs_n);
        ch_t idx = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (!cs_n[i]) idx = CH_W'(i);
        return idx;
    endfunction
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/hbi_access_decode.sv
module hbi_access_decode
    import hbi_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  strobe_t now_s,
    output access_t acc,
    output ch_t     ch_idx
);
    logic rd_prev, wr_prev;
    logic rd_fall, rd_rise, wr_rise, one_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_prev <= 1'b1;
            wr_prev <= 1'b1;
        end else begin
            rd_prev <= now_s.rd_n;
            wr_prev <= now_s.wr_n;
        end
    end

    always_comb begin
        rd_fall     = rd_prev & ~now_s.rd_n;
        rd_rise     = ~rd_prev & now_s.rd_n;
        wr_rise     = ~wr_prev & now_s.wr_n;
        one_sel     = sel_ok(now_s.cs_n);
        acc.rd_go   = rd_fall & one_sel;
        acc.rd_done = rd_rise;
        acc.wr_go   = (wr_rise && one_sel) ? ~now_s.cs_n : '0;
        ch_idx      = sel_idx(now_s.cs_n);
    end

    // R6 / R7: no write enable unless exactly one select is low
    a_r6_no_stray_write: assert property (@(posedge clk) disable iff (rst)
        !sel_ok(now_s.cs_n) |-> (acc.wr_go == '0));
    // R2 / R3: at most one channel written per edge
    a_r2_single_channel: assert property (@(posedge clk) disable iff (rst)
        $onehot0(acc.wr_go));
endmodule

// File: rtl/hbi_chan_regs.sv
module hbi_chan_regs
    import hbi_pkg::*;
#(
    parameter int CTRL_IDX = CTRL_ADDR,
    parameter int GATE_BIT = IRQ_EN_BIT
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  radr_t addr,
    input  byte_t wdata,
    output byte_t rdata,
    output logic  irq_en
);
    byte_t mem [NUM_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata  = mem[addr];
    assign irq_en = mem[CTRL_IDX][GATE_BIT];

    // R2 / R9: a write lands at its own address
    a_r9_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> mem[$past(addr)] == $past(wdata));
    // R8: gate bit follows a write to the control register
    a_r8_gate_tracks: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == radr_t'(CTRL_IDX)) |=> irq_en == $past(wdata[GATE_BIT]));
endmodule

// File: rtl/hbi_dual_front.sv
module hbi_dual_front
    import hbi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_a_n,
    input  logic              cs_b_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    input  logic              irq_a,
    input  logic              irq_b,
    output logic              int_a,
    output logic              int_a_oe,
    output logic              int_b,
    output logic              int_b_oe,
    output logic              aux_a_n,
    output logic              aux_b_n
);
    localparam int STB_W = $bits(strobe_t);
    localparam int AD_W  = ADDR_W + DATA_W;

    strobe_t           raw_s, now_s;
    logic [AD_W-1:0]   raw_ad, now_ad;
    radr_t             addr_s;
    byte_t             wdata_s;
    access_t           acc;
    ch_t               ch_idx;
    byte_t             bank_rd [NUM_CH];
    logic [NUM_CH-1:0] irq_en, irq_req, int_val;
    byte_t             hold_q;
    logic              oe_q;

    assign raw_s  = '{rd_n: rd_n, wr_n: wr_n, cs_n: {cs_b_n, cs_a_n}};
    assign raw_ad = {addr, data_in};
    assign {addr_s, wdata_s} = now_ad;

    hbi_sync #(.W(STB_W), .RST_VAL({STB_W{1'b1}})) u_sync_ctl (
        .clk(clk), .rst(rst), .d(raw_s), .q(now_s));

    hbi_sync #(.W(AD_W), .RST_VAL('0)) u_sync_dat (
        .clk(clk), .rst(rst), .d(raw_ad), .q(now_ad));

    hbi_access_decode u_dec (
        .clk(clk), .rst(rst), .now_s(now_s), .acc(acc), .ch_idx(ch_idx));

    assign irq_req = {irq_b, irq_a};

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        hbi_chan_regs u_regs (
            .clk(clk), .rst(rst), .wr_en(acc.wr_go[g]), .addr(addr_s),
            .wdata(wdata_s), .rdata(bank_rd[g]), .irq_en(irq_en[g]));
        assign int_val[g] = irq_en[g] & irq_req[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_q   <= 1'b0;
            hold_q <= '0;
        end else if (acc.rd_go) begin
            oe_q   <= 1'b1;
            hold_q <= bank_rd[ch_idx];
        end else if (acc.rd_done) begin
            oe_q   <= 1'b0;
            hold_q <= '0;
        end
    end

    assign data_out = hold_q;
    assign data_oe  = oe_q;
    assign int_a    = int_val[0];
    assign int_b    = int_val[1];
    assign int_a_oe = irq_en[0];
    assign int_b_oe = irq_en[1];
    assign aux_a_n  = ~irq_en[0];
    assign aux_b_n  = ~irq_en[1];

    // R5: bus released the cycle after the read strobe rises
    a_r5_bus_release: assert property (@(posedge clk) disable iff (rst)
        acc.rd_done |=> !data_oe && data_out == '0);
    // R4: read value held steady while the bus is driven
    a_r4_read_hold: assert property (@(posedge clk) disable iff (rst)
        (data_oe && !acc.rd_done && !acc.rd_go) |=> $stable(data_out));
    // R6: a read without a unique select never drives the bus
    a_r6_no_dual_read: assert property (@(posedge clk) disable iff (rst)
        (!data_oe && !sel_ok(now_s.cs_n)) |=> !data_oe);
endmodule

// File: tb/hbi_dual_front_tb.sv
module hbi_dual_front_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_a_n = 1'b1, cs_b_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [2:0] addr = '0;
    logic [7:0] data_in = '0;
    logic       irq_a = 1'b0, irq_b = 1'b0;
    logic [7:0] data_out;
    logic       data_oe, int_a, int_a_oe, int_b, int_b_oe, aux_a_n, aux_b_n;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] mdl [2][8];

    typedef struct {
        string      tag;
        logic       oe;
        logic [7:0] d;
    } exp_t;
    exp_t exp_q[$];
    event sample_ev;

    always #2 clk = ~clk;

    hbi_dual_front u_dut (
        .clk(clk), .rst(rst), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n), .addr(addr),
        .rd_n(rd_n), .wr_n(wr_n), .data_in(data_in), .data_out(data_out),
        .data_oe(data_oe), .irq_a(irq_a), .irq_b(irq_b), .int_a(int_a),
        .int_a_oe(int_a_oe), .int_b(int_b), .int_b_oe(int_b_oe),
        .aux_a_n(aux_a_n), .aux_b_n(aux_b_n));

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        foreach (mdl[c, a]) mdl[c][a] = 8'h00;
        @(negedge clk);
    endtask

    task automatic bus_write(input logic ca, input logic cb, input logic [2:0] a,
                             input logic [7:0] d);
        @(negedge clk);
        cs_a_n = ca; cs_b_n = cb; addr = a; data_in = d;
        @(negedge clk);
        wr_n = 1'b0;
        repeat (5) @(negedge clk);
        wr_n = 1'b1;
        repeat (5) @(negedge clk);
        cs_a_n = 1'b1; cs_b_n = 1'b1;
        if (!ca && cb)  mdl[0][a] = d;
        if (ca && !cb)  mdl[1][a] = d;
    endtask

    task automatic bus_read(input logic ca, input logic cb, input logic [2:0] a,
                            input string tag);
        exp_t e;
        @(negedge clk);
        cs_a_n = ca; cs_b_n = cb; addr = a;
        @(negedge clk);
        rd_n = 1'b0;
        repeat (6) @(negedge clk);
        e.tag = tag;
        e.oe  = (ca ^ cb);
        e.d   = !ca && cb ? mdl[0][a] : (ca && !cb ? mdl[1][a] : 8'h00);
        exp_q.push_back(e);
        ->sample_ev;
        @(negedge clk);
        rd_n = 1'b1;
        repeat (6) @(negedge clk);
        chk({tag, " R5 oe after release"}, {7'd0, data_oe}, 8'h00);
        chk({tag, " R5 data after release"}, data_out, 8'h00);
        cs_a_n = 1'b1; cs_b_n = 1'b1;
    endtask

    // monitor: pops the expected item and compares when the driver signals
    initial begin
        forever begin
            exp_t e;
            @(sample_ev);
            e = exp_q.pop_front();
            chk({e.tag, " oe"}, {7'd0, data_oe}, {7'd0, e.oe});
            chk({e.tag, " data"}, data_out, e.d);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_up();
    end

    initial begin
        do_reset();
        // R1 reset state at the ports
        chk("R1 data_oe", {7'd0, data_oe}, 8'h00);
        chk("R1 data_out", data_out, 8'h00);
        chk("R1 int oe", {6'd0, int_b_oe, int_a_oe}, 8'h00);
        chk("R1 aux", {6'd0, aux_b_n, aux_a_n}, 8'h03);
        for (int a = 0; a < 8; a++) bus_read(1'b0, 1'b1, 3'(a), "R1 A reg");
        for (int a = 0; a < 8; a++) bus_read(1'b1, 1'b0, 3'(a), "R1 B reg");

        // R2 / R3 / R9: fill both channels with distinct values
        for (int a = 0; a < 8; a++) bus_write(1'b0, 1'b1, 3'(a), 8'hA0 | 8'(a));
        for (int a = 0; a < 8; a++) bus_write(1'b1, 1'b0, 3'(a), 8'h40 | 8'(a));
        for (int a = 0; a < 8; a++) bus_read(1'b0, 1'b1, 3'(a), "R2 R9 A reg");
        for (int a = 0; a < 8; a++) bus_read(1'b1, 1'b0, 3'(a), "R3 R9 B reg");
        bus_write(1'b0, 1'b1, 3'd6, 8'h5A);
        bus_read(1'b0, 1'b1, 3'd6, "R2 A6 rewrite");
        bus_read(1'b1, 1'b0, 3'd6, "R3 B6 untouched");
        bus_read(1'b0, 1'b1, 3'd5, "R9 A5 neighbour");

        // R6: both selects low
        bus_write(1'b0, 1'b0, 3'd2, 8'hEE);
        bus_read(1'b0, 1'b0, 3'd2, "R6 dual read");
        bus_read(1'b0, 1'b1, 3'd2, "R6 A2 kept");
        bus_read(1'b1, 1'b0, 3'd2, "R6 B2 kept");

        // R7: no select
        bus_write(1'b1, 1'b1, 3'd3, 8'h99);
        bus_read(1'b1, 1'b1, 3'd3, "R7 no-select read");
        bus_read(1'b0, 1'b1, 3'd3, "R7 A3 kept");
        bus_read(1'b1, 1'b0, 3'd3, "R7 B3 kept");

        // R10: data changes while write strobe is low
        @(negedge clk);
        cs_b_n = 1'b0; addr = 3'd1; data_in = 8'h11;
        @(negedge clk);
        wr_n = 1'b0;
        repeat (3) @(negedge clk);
        data_in = 8'h22;
        repeat (4) @(negedge clk);
        wr_n = 1'b1;
        repeat (5) @(negedge clk);
        cs_b_n = 1'b1;
        mdl[1][1] = 8'h22;
        bus_read(1'b1, 1'b0, 3'd1, "R10 last byte");

        // R8: interrupt gating through bit 3 of register 4
        irq_a = 1'b1; irq_b = 1'b1;
        bus_write(1'b0, 1'b1, 3'd4, 8'h08);
        chk("R8 A enabled oe", {7'd0, int_a_oe}, 8'h01);
        chk("R8 A pin value", {7'd0, int_a}, 8'h01);
        chk("R8 A aux low", {7'd0, aux_a_n}, 8'h00);
        chk("R8 B still off", {5'd0, int_b_oe, int_b, aux_b_n}, 8'h01);
        irq_a = 1'b0;
        @(negedge clk);
        chk("R8 A follows request", {7'd0, int_a}, 8'h00);
        bus_write(1'b1, 1'b0, 3'd4, 8'hFF);
        chk("R8 B enabled", {5'd0, int_b_oe, int_b, aux_b_n}, 8'h06);
        bus_write(1'b0, 1'b1, 3'd4, 8'hF7);
        irq_a = 1'b1;
        @(negedge clk);
        chk("R8 A disabled", {5'd0, int_a_oe, int_a, aux_a_n}, 8'h01);
        bus_read(1'b0, 1'b1, 3'd4, "R8 A ctrl readback");

        // R1: reset again clears everything
        do_reset();
        chk("R1 reset int B", {5'd0, int_b_oe, int_b, aux_b_n}, 8'h01);
        bus_read(1'b0, 1'b1, 3'd0, "R1 A0 cleared");
        bus_read(1'b1, 1'b0, 3'd4, "R1 B4 cleared");

        repeat (4) @(negedge clk);
        chk("scoreboard drained", 8'(exp_q.size()), 8'h00);
        finish_up();
    end
endmodule